// File: doc/BRIEF.md
# Watchdog Counter with Option-Selected Activation and Stop Arbitration

This block is a supervisory down-counter that pulls the chip into reset if software stops servicing it. An 8-bit count starts at FEh and loses one on every prescaler tick (the system integrates it with a tick that comes once every 12 internal clocks). Software keeps the chip alive by writing a fresh count before the value runs out. When the count runs out, the block raises a one-cycle reset request, puts FEh back in the counter and drops any software enable.

Two static option inputs shape its behaviour. The activation option picks between a watchdog that always runs and one that sleeps until software arms it; once armed, only a reset disarms it. The external-stop option lets the level on the NMI pin decide whether a STOP request from the CPU may really halt the clock while the watchdog runs. Each STOP request gets exactly one verdict, STOP or WAIT, one cycle later. A real STOP taken while the watchdog runs freezes the count until the CPU reports that it has left STOP.

All pins are plain control and status signals; no streamed data passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `wdg_guard`

## Requirements
- R1: After `rst_ni` is released, `count_o` is FEh, `rst_req_o`, `halt_stop_o` and `halt_wait_o` are 0, and the software enable is clear.
- R2: While the watchdog is active and not frozen, each cycle with `tick_i` high lowers `count_o` by one at the next clock edge; without a tick the count holds.
- R3: A tick taken while the watchdog runs and the count is 01h or 00h raises `rst_req_o` for exactly one cycle, with `count_o` back at FEh in that same cycle and the software enable cleared.
- R4: A cycle with `wr_en_i` high loads `wr_data_i` into the counter at the next edge, whether or not the watchdog is enabled, and wins over a tick in the same cycle, including a tick that would otherwise time out.
- R5: With `opt_hw_act_i` = 0 the watchdog is idle until a write with `wr_arm_i` = 1; later writes with `wr_arm_i` = 0 do not disarm it; only `rst_ni` or a timeout disarms it.
- R6: With `opt_hw_act_i` = 1 the watchdog runs from reset without any write, and keeps running after a timeout.
- R7: While the watchdog is active and `opt_ext_stop_i` = 0, a STOP request yields WAIT and the count keeps falling on ticks.
- R8: While active with `opt_ext_stop_i` = 1, a STOP request yields WAIT if `nmi_lvl_i` is 0, and yields STOP and freezes the count if `nmi_lvl_i` is 1.
- R9: A `stop_exit_i` pulse ends the freeze; from the next cycle ticks decrement again.
- R10: While the watchdog is inactive, every STOP request yields STOP, regardless of the pins.
- R11: A `stop_req_i` pulse makes exactly one of `halt_stop_o` or `halt_wait_o` high for one cycle, in the cycle after the request; neither rises otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle count enable from the clock prescaler |
| opt_hw_act_i | input | 1 | Static option: 1 = always active, 0 = software-armed |
| opt_ext_stop_i | input | 1 | Static option: 1 = NMI pin level arbitrates STOP |
| nmi_lvl_i | input | 1 | Synchronised NMI pin level |
| wr_en_i | input | 1 | Software write strobe |
| wr_arm_i | input | 1 | Arm bit carried by the write |
| wr_data_i | input | 8 | Count value carried by the write |
| stop_req_i | input | 1 | One-cycle STOP instruction request from the CPU |
| stop_exit_i | input | 1 | One-cycle pulse: the CPU has left STOP |
| rst_req_o | output | 1 | One-cycle system reset request |
| halt_stop_o | output | 1 | Verdict pulse: real STOP granted |
| halt_wait_o | output | 1 | Verdict pulse: request turned into WAIT |
| count_o | output | 8 | Current counter value |

## Verification
The bench aims at the count boundary: a full run from FEh must fire on the 254th tick and not earlier, and a written value of zero must fire on the very next tick; a design that compares against zero after the decrement would wrap to FFh there and never reset. It drives a write and a tick into the same cycle at count 01h, where a design that lets the tick win would reset a chip that had just serviced its watchdog. It walks the STOP arbitration across both pin levels and both activation states, checking that the count truly holds through a frozen STOP and resumes only after the exit pulse, since a wrong design would either time out during a legal STOP or stay frozen forever. It also writes the arm bit as zero after arming, where a non-sticky enable would let software switch the watchdog off.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  localparam int unsigned WDG_CNT_W = 8;

  typedef enum logic [1:0] {
    HALT_NONE = 2'd0,
    HALT_WAIT = 2'd1,
    HALT_STOP = 2'd2
  } halt_e;

endpackage

// File: rtl/wdg_counter.sv
module wdg_counter
  import wdg_pkg::*;
#(
  parameter int unsigned    CNT_W  = WDG_CNT_W,
  parameter logic [CNT_W-1:0] RELOAD = {CNT_W{1'b1}} - 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             fire_o,
  output logic             rst_req_o,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             rst_q;
  logic             fire_now;

  // a tick at the last live value (or at zero after a write of zero) expires
  always_comb begin
    fire_now = run_i && tick_i && !load_i && (cnt_q <= LAST);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= RELOAD;
      rst_q <= 1'b0;
    end else begin
      rst_q <= fire_now;
      if (load_i) begin
        cnt_q <= load_val_i;
      end else if (fire_now) begin
        cnt_q <= RELOAD;
      end else if (run_i && tick_i) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign fire_o    = fire_now;
  assign rst_req_o = rst_q;
  assign cnt_o     = cnt_q;

  // R3
  rst_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_q |=> !rst_q);

  // R2
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !fire_now) |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) - 1'b1)));

endmodule

// File: rtl/wdg_enable.sv
module wdg_enable (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hw_act_i,
  input  logic arm_set_i,
  input  logic fire_i,
  output logic active_o
);

  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
    end else if (fire_i) begin
      armed_q <= 1'b0;
    end else if (arm_set_i) begin
      armed_q <= 1'b1;
    end
  end

  assign active_o = hw_act_i | armed_q;

  // R5
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !fire_i) |=> armed_q);

endmodule

// File: rtl/wdg_stop_arb.sv
module wdg_stop_arb
  import wdg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic ext_stop_i,
  input  logic nmi_lvl_i,
  input  logic stop_req_i,
  input  logic stop_exit_i,
  input  logic fire_i,
  output logic stop_go_o,
  output logic wait_go_o,
  output logic frozen_o
);

  halt_e verdict;
  logic  stop_go_q, wait_go_q, frozen_q;

  always_comb begin
    verdict = HALT_NONE;
    if (stop_req_i) begin
      if (!active_i) begin
        verdict = HALT_STOP;
      end else if (ext_stop_i && nmi_lvl_i) begin
        verdict = HALT_STOP;
      end else begin
        verdict = HALT_WAIT;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_go_q <= 1'b0;
      wait_go_q <= 1'b0;
      frozen_q  <= 1'b0;
    end else begin
      stop_go_q <= (verdict == HALT_STOP);
      wait_go_q <= (verdict == HALT_WAIT);
      if (fire_i || stop_exit_i) begin
        frozen_q <= 1'b0;
      end else if (active_i && verdict == HALT_STOP) begin
        frozen_q <= 1'b1;
      end
    end
  end

  assign stop_go_o = stop_go_q;
  assign wait_go_o = wait_go_q;
  assign frozen_o  = frozen_q;

  // R11
  one_verdict_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({stop_go_q, wait_go_q}));

  // R11
  answered_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_req_i |=> (stop_go_q || wait_go_q));

  // R10
  idle_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_req_i && !active_i) |=> stop_go_q);

  // R9
  thaw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_exit_i |=> !frozen_q);

endmodule

// File: rtl/wdg_guard.sv
module wdg_guard
  import wdg_pkg::*;
#(
  parameter int unsigned CNT_W = WDG_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             opt_hw_act_i,
  input  logic             opt_ext_stop_i,
  input  logic             nmi_lvl_i,
  input  logic             wr_en_i,
  input  logic             wr_arm_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             stop_req_i,
  input  logic             stop_exit_i,
  output logic             rst_req_o,
  output logic             halt_stop_o,
  output logic             halt_wait_o,
  output logic [CNT_W-1:0] count_o
);

  localparam logic [CNT_W-1:0] RELOAD = {CNT_W{1'b1}} - 1'b1;

  logic active, frozen, fire;

  wdg_enable u_enable (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hw_act_i  (opt_hw_act_i),
    .arm_set_i (wr_en_i & wr_arm_i),
    .fire_i    (fire),
    .active_o  (active)
  );

  wdg_counter #(.CNT_W(CNT_W), .RELOAD(RELOAD)) u_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .run_i      (active & ~frozen),
    .load_i     (wr_en_i),
    .load_val_i (wr_data_i),
    .fire_o     (fire),
    .rst_req_o  (rst_req_o),
    .cnt_o      (count_o)
  );

  wdg_stop_arb u_stop (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (active),
    .ext_stop_i  (opt_ext_stop_i),
    .nmi_lvl_i   (nmi_lvl_i),
    .stop_req_i  (stop_req_i),
    .stop_exit_i (stop_exit_i),
    .fire_i      (fire),
    .stop_go_o   (halt_stop_o),
    .wait_go_o   (halt_wait_o),
    .frozen_o    (frozen)
  );

  // R8
  freeze_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frozen && !wr_en_i) |=> $stable(count_o));

  // R3
  reload_on_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (count_o == RELOAD));

  // R6
  hw_runs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opt_hw_act_i && tick_i && !frozen && !wr_en_i && count_o > CNT_W'(1))
      |=> (count_o == $past(count_o) - 1'b1));

endmodule

// File: tb/tb_wdg_guard.sv
module tb_wdg_guard;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, hw_act = 1'b0, ext_stop = 1'b0, nmi = 1'b0;
  logic       wr_en = 1'b0, wr_arm = 1'b0, stop_req = 1'b0, stop_exit = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rst_req, halt_stop, halt_wait;
  logic [7:0] count;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wdg_guard dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .opt_hw_act_i(hw_act), .opt_ext_stop_i(ext_stop), .nmi_lvl_i(nmi),
    .wr_en_i(wr_en), .wr_arm_i(wr_arm), .wr_data_i(wr_data),
    .stop_req_i(stop_req), .stop_exit_i(stop_exit),
    .rst_req_o(rst_req), .halt_stop_o(halt_stop), .halt_wait_o(halt_wait),
    .count_o(count)
  );

  // {wr_en, arm, data[7:0], tick, stop_req, stop_exit, nmi, exp_cnt[7:0], exp_rst, exp_stop, exp_wait}
  // run with software activation and external stop control on
  localparam int NV = 22;
  localparam logic [24:0] VEC [NV] = '{
    {1'b0,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0, 8'hFE,1'b0,1'b0,1'b0},
    {1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,1'b0, 8'hFE,1'b0,1'b1,1'b0},
    {1'b1,1'b1,8'h05,1'b0,1'b0,1'b0,1'b0, 8'h05,1'b0,1'b0,1'b0},
    {1'b0,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0, 8'h04,1'b0,1'b0,1'b0},
    {1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,1'b0, 8'h04,1'b0,1'b0,1'b1},
    {1'b0,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0, 8'h03,1'b0,1'b0,1'b0},
    {1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,1'b1, 8'h03,1'b0,1'b1,1'b0},
    {1'b0,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0, 8'h03,1'b0,1'b0,1'b0},
    {1'b0,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0, 8'h03,1'b0,1'b0,1'b0},
    {1'b0,1'b0,8'h00,1'b0,1'b0,1'b1,1'b0, 8'h03,1'b0,1'b0,1'b0},
    {1'b0,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0, 8'h02,1'b0,1'b0,1'b0},
    {1'b0,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0, 8'h01,1'b0,1'b0,1'b0},
    {1'b0,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0, 8'hFE,1'b1,1'b0,1'b0},
    {1'b0,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0, 8'hFE,1'b0,1'b0,1'b0},
    {1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,1'b0, 8'hFE,1'b0,1'b1,1'b0},
    {1'b1,1'b0,8'h02,1'b0,1'b0,1'b0,1'b0, 8'h02,1'b0,1'b0,1'b0},
    {1'b0,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0, 8'h02,1'b0,1'b0,1'b0},
    {1'b1,1'b1,8'h03,1'b1,1'b0,1'b0,1'b0, 8'h03,1'b0,1'b0,1'b0},
    {1'b0,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0, 8'h02,1'b0,1'b0,1'b0},
    {1'b0,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0, 8'h01,1'b0,1'b0,1'b0},
    {1'b1,1'b0,8'h10,1'b1,1'b0,1'b0,1'b0, 8'h10,1'b0,1'b0,1'b0},
    {1'b0,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0, 8'h0F,1'b0,1'b0,1'b0}
  };

  function automatic string vec_req(int i);
    case (i)
      0, 16:      return "R5 idle until armed";
      1, 14:      return "R10 inactive STOP";
      2, 15:      return "R4 write loads";
      3, 5, 10, 11, 21: return "R2 decrement";
      4:          return "R8 NMI low gives WAIT";
      6:          return "R8 NMI high gives STOP";
      7, 8:       return "R8 frozen count";
      9:          return "R9 exit keeps value";
      12:         return "R3 timeout";
      13:         return "R3 enable cleared";
      17:         return "R4 write beats tick";
      18, 19:     return "R5 armed runs";
      default:    return "R4 write beats timeout";
    endcase
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic chk_out(input string rq, input logic [7:0] ec, input logic er, es, ew);
    chk(rq, {21'd0, count, rst_req, halt_stop, halt_wait}, {21'd0, ec, er, es, ew});
  endtask

  // drive at a falling edge, let one rising edge pass, return at the next falling edge
  task automatic step(input logic we, ar, input logic [7:0] d,
                      input logic tk, sr, se, nm);
    wr_en = we; wr_arm = ar; wr_data = d;
    tick = tk; stop_req = sr; stop_exit = se; nmi = nm;
    @(negedge clk);
    wr_en = 1'b0; wr_arm = 1'b0; tick = 1'b0; stop_req = 1'b0; stop_exit = 1'b0;
  endtask

  task automatic do_reset(input logic hw, input logic ext);
    rst_n = 1'b0;
    hw_act = hw; ext_stop = ext;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);

    // R1 reset state
    do_reset(1'b0, 1'b1);
    chk_out("R1 reset state", 8'hFE, 1'b0, 1'b0, 1'b0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][24], VEC[i][23], VEC[i][22:15], VEC[i][14], VEC[i][13], VEC[i][12], VEC[i][11]);
      chk_out(vec_req(i), VEC[i][10:3], VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R5 sticky enable, R7 WAIT with counting, external stop off
    do_reset(1'b0, 1'b0);
    step(1'b1, 1'b1, 8'h03, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 8'h05, 1'b0, 1'b0, 1'b0, 1'b0);
    chk_out("R4 reload while armed", 8'h05, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
    chk_out("R5 arm=0 write does not disarm", 8'h04, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1);
    chk_out("R7 STOP becomes WAIT and count runs", 8'h03, 1'b0, 1'b0, 1'b1);

    // R3 a written zero expires on the next tick
    step(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    chk_out("R4 write zero", 8'h00, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
    chk_out("R3 zero expires", 8'hFE, 1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    chk_out("R3 one-cycle pulse", 8'hFE, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
    chk_out("R5 disarmed by timeout", 8'hFE, 1'b0, 1'b0, 1'b0);

    // R1 reset clears the software enable
    step(1'b1, 1'b1, 8'h08, 1'b0, 1'b0, 1'b0, 1'b0);
    do_reset(1'b0, 1'b0);
    step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
    chk_out("R1 reset disarms", 8'hFE, 1'b0, 1'b0, 1'b0);

    // R6 hardware activation, full timeout
    do_reset(1'b1, 1'b0);
    step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
    chk_out("R6 runs without write", 8'hFD, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 252; k++) begin
      step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
      if (rst_req) chk("R3 no early reset", {31'd0, rst_req}, 32'd0);
    end
    chk_out("R3 count 01 after 253 ticks", 8'h01, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
    chk_out("R3 reset on 254th tick", 8'hFE, 1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
    chk_out("R6 still runs after timeout", 8'hFD, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1);
    chk_out("R7 hw mode STOP becomes WAIT", 8'hFD, 1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    chk_out("R11 verdict lasts one cycle", 8'hFD, 1'b0, 1'b0, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired (all requirements) actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule